// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block holds the 32-bit floating-point status and control word of an execution pipeline. Each time an arithmetic operation completes, the arithmetic unit presents a vector of the exception conditions the operation raised. The recorder ORs them into sticky status bits and sets the overall exception summary when any condition was raised. It recomputes the invalid-operation summary from the sticky invalid sub-cause bits. It then clears and rebuilds the enabled-exception summary from the sticky bits and their enable bits. The result drives a trap request for the operation.

The recorder also reports what the sequencer may do next. When the operation does not trap, it gives one pulse to advance the program counter by one instruction and, if requested, one pulse that commits the operation's base-register update. When the operation asks for a record, the top four status bits, as they stood before this operation's flags were merged, are copied into a 4-bit condition field. A direct write port loads the whole word and wins over an operation in the same cycle.

Top module: `fp_status_recorder`

## Requirements
- R1: A synchronous active-high reset clears the status word, the condition field, `trap_q`, `adv_pc` and `wb_commit` to zero.
- R2: Each raised flag sets one status bit. The flag index and the status bit it sets are: 0→28 (overflow), 1→27 (underflow), 2→26 (divide by zero), 3→25 (inexact), 4→29 (invalid), 5→24 (signalling NaN), 6→23 (inf−inf), 7→22 (inf/inf), 8→21 (0/0), 9→20 (inf×0), 10→19 (invalid compare), 11→10 (software request), 12→9 (invalid square root), 13→8 (invalid integer convert).
- R3: An operation never clears a status bit, with the single exception of bit 30.
- R4: Bit 31 (exception summary) is set by an operation with any flag raised. An operation with no flags leaves it unchanged.
- R5: After every operation, bit 29 (invalid summary) is set if any of the sub-cause bits 24:19 or 10:8 is set. This includes sub-cause bits that were loaded by a direct write.
- R6: On every operation, bit 30 (enabled-exception summary) is cleared first. It is then set when any of these bit pairs of the merged word are both set: 29&7, 28&6, 27&5, 26&4, 25&3. This happens even when no flags are raised.
- R7: `trap_q` is high for the cycle after an operation exactly when bit 30 of the new word is set. It is low in every other cycle.
- R8: `adv_pc` pulses for one cycle after every operation that does not trap. `wb_commit` pulses with it only when `wb_req` was high. Neither pulses after a trapping operation.
- R9: An operation with `rec_en` high copies bits 31:28 of the status word from before the merge into `cr_field`. Otherwise `cr_field` holds its value.
- R10: `wr_en` loads all 32 bits of `wr_data`. The operation presented in the same cycle is discarded: no trap, no advance, no commit, and no change to `cr_field`.
- R11: An operation leaves bits 18:11, 7:3 and 2:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation completes this cycle |
| exc_flags | input | 14 | Exception conditions raised by the operation (index map in R2) |
| rec_en | input | 1 | Operation requests the condition-field copy |
| wb_req | input | 1 | Operation has a base-register update pending |
| wr_en | input | 1 | Direct load of the status word |
| wr_data | input | 32 | Value for the direct load |
| status_q | output | 32 | Status and control word |
| cr_field | output | 4 | Condition field written by record operations |
| trap_q | output | 1 | Trap request for the last operation |
| adv_pc | output | 1 | Advance the program counter by 4 |
| wb_commit | output | 1 | Commit the pending base-register update |

## Verification
On every cycle, the embedded assertions check stickiness, untouched fields, the invalid summary after an operation, the exception summary on a flagged operation, trap agreeing with bit 30, the ordering of the advance and commit pulses, direct-write loading and the condition-field copy and hold. What the assertions cannot establish is that each flag lands on its own bit and that the enabled summary is right for each of the five pairs. The bench's sweep covers these: every single flag, every enable combination against every trap class, and summaries rebuilt on flag-free operations after direct writes. A long pseudo-random stream compares the whole word against an arithmetic model.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int STAT_W = 32;
  localparam int FLAG_W = 14;
  localparam int CR_W   = 4;

  // summary bits
  localparam int B_FX  = 31;
  localparam int B_FEX = 30;
  localparam int B_VX  = 29;

  // enabled-summary pairs: sticky bit and its enable
  localparam int NPAIR = 5;
  localparam int PAIR_STICKY [NPAIR] = '{29, 28, 27, 26, 25};
  localparam int PAIR_ENABLE [NPAIR] = '{7, 6, 5, 4, 3};

  // invalid sub-cause bits: 24..19 and 10..8
  localparam logic [STAT_W-1:0] SUB_MASK  = 32'h01F8_0700;
  // bits an operation must never touch
  localparam logic [STAT_W-1:0] KEEP_MASK = 32'h0007_F8FF;

  // flag vector index -> status bit
  function automatic int flag_bit(input int idx);
    case (idx)
      0:  return 28;
      1:  return 27;
      2:  return 26;
      3:  return 25;
      4:  return 29;
      5:  return 24;
      6:  return 23;
      7:  return 22;
      8:  return 21;
      9:  return 20;
      10: return 19;
      11: return 10;
      12: return 9;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/fpsr_merge.sv
module fpsr_merge import fpsr_pkg::*; #(
  parameter int SW = STAT_W,
  parameter int FW = FLAG_W
) (
  input  logic [SW-1:0] cur,
  input  logic [FW-1:0] flags,
  output logic [SW-1:0] merged
);
  logic [FW-1:0][SW-1:0] set_mask;

  genvar g;
  generate
    for (g = 0; g < FW; g++) begin : g_flag
      localparam int POS = flag_bit(g);
      always_comb begin
        set_mask[g]      = '0;
        set_mask[g][POS] = flags[g];
      end
    end
  endgenerate

  logic [SW-1:0] or_acc;
  always_comb begin
    or_acc = cur;
    for (int i = 0; i < FW; i++) or_acc = or_acc | set_mask[i];
    if (|flags) or_acc[B_FX] = 1'b1;
    if (|(or_acc & SUB_MASK)) or_acc[B_VX] = 1'b1;
    merged = or_acc;
  end
endmodule

// File: rtl/fpsr_summary.sv
module fpsr_summary import fpsr_pkg::*; #(
  parameter int SW = STAT_W
) (
  input  logic [SW-1:0] merged,
  output logic [SW-1:0] final_word,
  output logic          fex
);
  logic [NPAIR-1:0] pair_hit;

  genvar p;
  generate
    for (p = 0; p < NPAIR; p++) begin : g_pair
      assign pair_hit[p] = merged[PAIR_STICKY[p]] & merged[PAIR_ENABLE[p]];
    end
  endgenerate

  assign fex = |pair_hit;

  always_comb begin
    final_word        = merged;
    final_word[B_FEX] = fex;
  end
endmodule

// File: rtl/fpsr_record.sv
module fpsr_record #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [CW-1:0] src,
  output logic [CW-1:0] cr_q
);
  always_ff @(posedge clk) begin
    if (rst)       cr_q <= '0;
    else if (take) cr_q <= src;
  end

  // R9
  cr_copy_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (cr_q == $past(src)));
  // R9
  cr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(cr_q));
endmodule

// File: rtl/fp_status_recorder.sv
module fp_status_recorder import fpsr_pkg::*; #(
  parameter int SW = STAT_W,
  parameter int FW = FLAG_W,
  parameter int CW = CR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [FW-1:0] exc_flags,
  input  logic          rec_en,
  input  logic          wb_req,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  output logic [SW-1:0] status_q,
  output logic [CW-1:0] cr_field,
  output logic          trap_q,
  output logic          adv_pc,
  output logic          wb_commit
);
  logic [SW-1:0] merged, final_word;
  logic          fex;
  logic          op_go;

  assign op_go = op_valid & ~wr_en;

  fpsr_merge #(.SW(SW), .FW(FW)) u_merge (
    .cur(status_q), .flags(exc_flags), .merged(merged)
  );

  fpsr_summary #(.SW(SW)) u_sum (
    .merged(merged), .final_word(final_word), .fex(fex)
  );

  fpsr_record #(.CW(CW)) u_rec (
    .clk(clk), .rst(rst), .take(op_go & rec_en),
    .src(status_q[SW-1 -: CW]), .cr_q(cr_field)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      trap_q    <= 1'b0;
      adv_pc    <= 1'b0;
      wb_commit <= 1'b0;
    end else if (wr_en) begin
      status_q  <= wr_data;
      trap_q    <= 1'b0;
      adv_pc    <= 1'b0;
      wb_commit <= 1'b0;
    end else if (op_valid) begin
      status_q  <= final_word;
      trap_q    <= fex;
      adv_pc    <= ~fex;
      wb_commit <= wb_req & ~fex;
    end else begin
      trap_q    <= 1'b0;
      adv_pc    <= 1'b0;
      wb_commit <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status_q == '0 && !trap_q && !adv_pc && !wb_commit));
  // R3
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    op_go |=> ((($past(status_q) & ~(SW'(1) << B_FEX)) & ~status_q) == '0));
  // R4
  summary_set_chk: assert property (@(posedge clk) disable iff (rst)
    (op_go && (exc_flags != '0)) |=> status_q[B_FX]);
  // R5
  invalid_sum_chk: assert property (@(posedge clk) disable iff (rst)
    op_go |=> (((status_q & SUB_MASK) == '0) || status_q[B_VX]));
  // R7
  trap_match_chk: assert property (@(posedge clk) disable iff (rst)
    op_go |=> (trap_q == status_q[B_FEX]));
  // R7
  trap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_go |=> !trap_q);
  // R8
  adv_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    adv_pc |-> !trap_q);
  // R8
  commit_needs_adv_chk: assert property (@(posedge clk) disable iff (rst)
    wb_commit |-> adv_pc);
  // R10
  direct_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (status_q == $past(wr_data) && !adv_pc && !trap_q));
  // R11
  untouched_chk: assert property (@(posedge clk) disable iff (rst)
    op_go |=> (((status_q ^ $past(status_q)) & KEEP_MASK) == '0));
endmodule

// File: tb/tb_fp_status_recorder.sv
module tb_fp_status_recorder;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SUBS = 32'h01F8_0700;
  localparam int POS [14] = '{28, 27, 26, 25, 29, 24, 23, 22, 21, 20, 19, 10, 9, 8};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [13:0] exc_flags = '0;
  logic        rec_en = 1'b0;
  logic        wb_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_q;
  logic [3:0]  cr_field;
  logic        trap_q, adv_pc, wb_commit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_stat;
  logic [3:0]  m_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_status_recorder dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .exc_flags(exc_flags),
    .rec_en(rec_en), .wb_req(wb_req), .wr_en(wr_en), .wr_data(wr_data),
    .status_q(status_q), .cr_field(cr_field), .trap_q(trap_q),
    .adv_pc(adv_pc), .wb_commit(wb_commit)
  );

  function automatic logic [31:0] model(input logic [31:0] s, input logic [13:0] f);
    logic [31:0] n;
    n = s;
    for (int i = 0; i < 14; i++) if (f[i]) n[POS[i]] = 1'b1;
    if (f != 0) n[31] = 1'b1;
    if ((n & SUBS) != 0) n[29] = 1'b1;
    n[30] = (n[29] & n[7]) | (n[28] & n[6]) | (n[27] & n[5]) |
            (n[26] & n[4]) | (n[25] & n[3]);
    return n;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: drive away from the edge, sample a quarter period after it
  task automatic step(input logic op, input logic [13:0] f, input logic rec,
                      input logic wbr, input logic we, input logic [31:0] wd,
                      input string req);
    logic et, ea, ew;
    op_valid = op; exc_flags = f; rec_en = rec; wb_req = wbr;
    wr_en = we; wr_data = wd;
    @(posedge clk);
    #(CLK_PERIOD/4);
    op_valid = 1'b0; exc_flags = '0; rec_en = 1'b0; wb_req = 1'b0;
    wr_en = 1'b0; wr_data = '0;
    et = 0; ea = 0; ew = 0;
    if (we) m_stat = wd;
    else if (op) begin
      logic [31:0] n;
      n = model(m_stat, f);
      if (rec) m_cr = m_stat[31:28];
      m_stat = n;
      et = n[30]; ea = !n[30]; ew = wbr && !n[30];
    end
    chk(req, "status", status_q, m_stat);
    chk(req, "cr", {28'd0, cr_field}, {28'd0, m_cr});
    chk(req, "trap", {31'd0, trap_q}, {31'd0, et});
    chk(req, "adv", {31'd0, adv_pc}, {31'd0, ea});
    chk(req, "commit", {31'd0, wb_commit}, {31'd0, ew});
  endtask

  task automatic wr(input logic [31:0] v, input string req);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, v, req);
  endtask

  task automatic op(input logic [13:0] f, input logic rec, input logic wbr,
                    input string req);
    step(1'b1, f, rec, wbr, 1'b0, '0, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #(CLK_PERIOD/4);
    rst = 1'b0;
    m_stat = '0; m_cr = '0;
    chk("R1", "status", status_q, 32'd0);
    chk("R1", "cr", {28'd0, cr_field}, 32'd0);
    chk("R1", "pulses", {29'd0, trap_q, adv_pc, wb_commit}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lfsr;
    m_stat = '0; m_cr = '0;
    do_reset();

    // R2: every flag alone lands on its own bit
    for (int i = 0; i < 14; i++) begin
      wr(32'd0, "R10");
      op(14'(1) << i, 1'b1, 1'b1, "R2");
    end

    // R3 R9: accumulate all flags one by one with record copies
    wr(32'd0, "R10");
    for (int i = 0; i < 14; i++) op(14'(1) << i, 1'b1, 1'b0, "R3");
    // R4: flag-free operation keeps FX
    op(14'd0, 1'b1, 1'b0, "R4");

    // R6 R7 R8: every enable combination against every trap class
    for (int en = 0; en < 32; en++) begin
      for (int c = 0; c < 5; c++) begin
        logic [13:0] f;
        case (c)
          0: f = 14'h0010;
          1: f = 14'h0001;
          2: f = 14'h0002;
          3: f = 14'h0004;
          default: f = 14'h0008;
        endcase
        wr(32'(en) << 3, "R10");
        op(f, 1'b0, 1'b1, "R6");
      end
    end

    // R6: summary rebuilt on a flag-free op after direct writes
    wr(32'h1000_0040, "R10");
    op(14'd0, 1'b0, 1'b1, "R6");
    wr(32'h4000_0000, "R10");
    op(14'd0, 1'b0, 1'b1, "R6");

    // R5: sub-cause loaded by a write raises the invalid summary
    wr(32'h0000_0400, "R10");
    op(14'd0, 1'b0, 1'b0, "R5");
    wr(32'h0080_0080, "R10");
    op(14'd0, 1'b1, 1'b1, "R5");

    // R10: write wins over a simultaneous operation
    wr(32'hF000_0000, "R10");
    op(14'd0, 1'b1, 1'b0, "R9");
    step(1'b1, 14'h0001, 1'b1, 1'b1, 1'b1, 32'h0000_0040, "R10");

    // R11: untouched fields survive an all-flags operation
    wr(32'h0007_F807, "R10");
    op(14'h3FFF, 1'b0, 1'b1, "R11");
    wr(32'h0007_F8FF, "R10");
    op(14'h3FFF, 1'b1, 1'b1, "R11");

    // pseudo-random stream
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'd0)
        wr(lfsr & 32'hBFFF_FFFF, "R10");
      else if (lfsr[6:4] == 3'd0)
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R7");
      else
        op(lfsr[17:4] & lfsr[31:18] & {14{lfsr[25]}}, lfsr[26], lfsr[27], "R3");
    end

    // R1: reset in the middle of activity
    wr(32'hFFFF_FFFF, "R10");
    op(14'h0001, 1'b1, 1'b0, "R9");
    do_reset();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule